// File: doc/BRIEF.md
# Audio Link Reset and Presence Status

This block sits on the controller side of a serial audio link. It drives the active-low link reset. It also records which of the three codec data-input lines reported a codec when the link last came out of reset. Software controls the link through one control bit. Writing 1 starts the link and writing 0 holds it in reset. The bit does not read back the written value. It reads back the real link state, so software polls it after each write until it reads back what was written.

Taking the link out of reset makes the attached codecs enumerate again. For a fixed window of clocks after the link leaves reset, the block samples each data-input line. A line seen high sets its presence bit. The presence bits are sticky. A link reset does not clear them. Software clears them by writing ones.

Top module: `alink_reset_ctrl`

## Requirements
- R1: After system reset, `linkResetN` is 0, the control register (address 0) reads 0, and the status register (address 1) reads 0.
- R2: A write of 1 to bit 0 at address 0, made while the link is held in reset, raises `linkResetN` at the START_DLY-th clock edge after the edge that samples the write. Read bit 0 at address 0 reports 1 from that edge on, and 0 before it.
- R3: A write of 0 to bit 0 at address 0 drops `linkResetN` at the edge that samples the write. Read bit 0 reports 0 from that same edge, well within 4 clocks.
- R4: A write of 0 while the link is still waking cancels the start-up. The link stays in reset no matter how long afterwards.
- R5: For the DETECT_WIN clock edges that follow the edge at which `linkResetN` rises, a high level on `sdIn[i]` sets status bit i. Status bit i is bit i at address 1, for i in 0..2.
- R6: Outside that window, the level on `sdIn` does not change the status bits.
- R7: A write to address 1 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R8: Entering link reset does not clear the status bits.
- R9: When a clear write and a detection hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 = control, 1 = status |
| regWrData | input | 8 | Write data |
| sdIn | input | 3 | Codec data-input lines |
| linkResetN | output | 1 | Active-low link reset |
| regRdData | output | 8 | Read data for the selected register, combinational on `regAddr` |

## Verification
Read data is combinational on the address. Every register result therefore appears after the clock edge that samples the cause:
- A link release appears START_DLY edges after the edge that samples the write.
- A link entry into reset appears at the sampling edge itself.
- A status set or clear appears at the sampling edge itself.

The bench drives inputs just after a rising edge and compares every output on the falling edge against a behavioural model, which is stepped on the same rising edges. The directed checks measure the release and entry latencies by counting cycles from the recorded sampling edge to the first falling edge that shows the new state. They compare the count with START_DLY and with zero exactly.

// File: rtl/alink_pkg.sv
package alink_pkg;
  typedef enum logic [1:0] {
    LINK_HELD    = 2'd0,
    LINK_WAKING  = 2'd1,
    LINK_RUNNING = 2'd2
  } linkState_e;

  typedef struct packed {
    logic linkUp;
    logic waking;
    logic sampleEn;
  } linkStrb_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/alink_ctrl.sv
module alink_ctrl
  import alink_pkg::*;
#(
  parameter int START_DLY  = 20,
  parameter int DETECT_WIN = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWr,
  input  logic      ctrlVal,
  output linkStrb_t strb
);
  localparam int DLY_W = $clog2(START_DLY + 1);
  localparam int WIN_W = $clog2(DETECT_WIN + 1);

  linkState_e       state;
  logic [DLY_W-1:0] dlyCnt;
  logic [WIN_W-1:0] winCnt;
  logic             sampleEn;

  assign sampleEn = (state == LINK_RUNNING) && (winCnt < WIN_W'(DETECT_WIN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= LINK_HELD;
      dlyCnt <= '0;
      winCnt <= '0;
    end else begin
      if (ctrlWr && !ctrlVal) begin
        state <= LINK_HELD;
      end else if (state == LINK_HELD && ctrlWr) begin
        state  <= LINK_WAKING;
        dlyCnt <= '0;
      end else if (state == LINK_WAKING) begin
        if (dlyCnt == DLY_W'(START_DLY - 1)) begin
          state  <= LINK_RUNNING;
          winCnt <= '0;
        end else begin
          dlyCnt <= dlyCnt + 1'b1;
        end
      end
      if (sampleEn) winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    strb.linkUp   = (state == LINK_RUNNING);
    strb.waking   = (state == LINK_WAKING);
    strb.sampleEn = sampleEn;
  end
endmodule

// File: rtl/alink_status.sv
module alink_status
  import alink_pkg::*;
#(
  parameter int NUM_SDIN = 3,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                statWr,
  input  logic [NUM_SDIN-1:0] clrMask,
  input  logic                regAddr,
  input  logic [NUM_SDIN-1:0] sdIn,
  input  linkStrb_t           strb,
  output logic [NUM_SDIN-1:0] statusQ,
  output logic [DATA_W-1:0]   regRdData
);
  for (genvar i = 0; i < NUM_SDIN; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN)                         statusQ[i] <= 1'b0;
      else if (strb.sampleEn && sdIn[i]) statusQ[i] <= 1'b1;
      else if (statWr && clrMask[i])     statusQ[i] <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) regRdData[0] = strb.linkUp;
    else                      regRdData[NUM_SDIN-1:0] = statusQ;
  end
endmodule

// File: rtl/alink_reset_ctrl.sv
module alink_reset_ctrl
  import alink_pkg::*;
#(
  parameter int START_DLY  = 20,
  parameter int DETECT_WIN = 64,
  parameter int NUM_SDIN   = 3,
  parameter int DATA_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [NUM_SDIN-1:0] sdIn,
  output logic                linkResetN,
  output logic [DATA_W-1:0]   regRdData
);
  linkStrb_t           strb;
  logic [NUM_SDIN-1:0] statusQ;
  logic                ctrlWr;
  logic                statWr;

  assign ctrlWr     = regWrEn && (regAddr == ADDR_CTRL);
  assign statWr     = regWrEn && (regAddr == ADDR_STAT);
  assign linkResetN = strb.linkUp;

  alink_ctrl #(.START_DLY(START_DLY), .DETECT_WIN(DETECT_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlVal(regWrData[0]), .strb(strb)
  );

  alink_status #(.NUM_SDIN(NUM_SDIN), .DATA_W(DATA_W)) u_stat (
    .clk(clk), .rstN(rstN), .statWr(statWr), .clrMask(regWrData[NUM_SDIN-1:0]),
    .regAddr(regAddr), .sdIn(sdIn), .strb(strb), .statusQ(statusQ),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/alink_chk.sv
module alink_chk
  import alink_pkg::*;
#(
  parameter int NUM_SDIN = 3,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic                regAddr,
  input logic [DATA_W-1:0]   regWrData,
  input logic [NUM_SDIN-1:0] sdIn,
  input logic                linkResetN,
  input linkStrb_t           strb,
  input logic [NUM_SDIN-1:0] statusQ
);
  AST_RISE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkResetN) |-> $past(strb.waking)); // R2
  AST_ENTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CTRL && !regWrData[0]) |=> (!linkResetN && !strb.waking)); // R3
  AST_DETECT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleEn |=> ((statusQ & $past(sdIn)) == $past(sdIn))); // R5
  AST_NO_LATE_SET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleEn |=> ((statusQ & ~$past(statusQ)) == '0)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_STAT && !strb.sampleEn)
      |=> ((statusQ & $past(regWrData[NUM_SDIN-1:0])) == '0)); // R7
  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_STAT) |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R8
endmodule

bind alink_reset_ctrl alink_chk #(.NUM_SDIN(NUM_SDIN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .sdIn(sdIn), .linkResetN(linkResetN), .strb(strb), .statusQ(statusQ)
);

// File: tb/test_alink_reset_ctrl.sv
module test_alink_reset_ctrl;
  localparam int N   = 20;
  localparam int WIN = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [2:0] sdIn = '0;
  logic       linkResetN;
  logic [7:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int lastWrCyc = 0;
  bit done = 0;

  // behavioural reference model
  int mState = 0;   // 0 held, 1 waking, 2 running
  int mCnt = 0;
  int mWin = 0;
  int mStat = 0;

  alink_reset_ctrl #(.START_DLY(N), .DETECT_WIN(WIN)) i_alink_reset_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .sdIn(sdIn), .linkResetN(linkResetN), .regRdData(regRdData)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int nxt;
    bit samp;
    cyc++;
    if (!rstN) begin
      mState = 0; mCnt = 0; mWin = 0; mStat = 0;
    end else begin
      samp = (mState == 2) && (mWin < WIN);
      nxt = mStat;
      if (regWrEn && regAddr) nxt = nxt & ~int'(regWrData[2:0]);
      if (samp) begin
        nxt = nxt | int'(sdIn);
        mWin++;
      end
      mStat = nxt;
      if (regWrEn && !regAddr && !regWrData[0]) mState = 0;
      else if (mState == 0 && regWrEn && !regAddr) begin mState = 1; mCnt = 0; end
      else if (mState == 1) begin
        if (mCnt == N - 1) begin mState = 2; mWin = 0; end
        else mCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk("R2/R3 linkResetN", int'(linkResetN), (mState == 2) ? 1 : 0);
      if (!regAddr) chk("R2/R3 ctrl readback", int'(regRdData), (mState == 2) ? 1 : 0);
      else          chk("R5-R9 status readback", int'(regRdData), mStat);
    end
  end

  task automatic regWrite(input logic a, input logic [7:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #2;
    lastWrCyc = cyc;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readStat(input string req, input int exp);
    @(posedge clk); #2;
    regAddr = 1'b1;
    @(negedge clk);
    chk(req, int'(regRdData[2:0]), exp);
    @(posedge clk); #2;
    regAddr = 1'b0;
  endtask

  task automatic startLink();
    int guard = 0;
    regWrite(1'b0, 8'h01);
    @(negedge clk);
    while (regRdData[0] !== 1'b1 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk("R2 release latency", cyc - lastWrCyc, N);
    chk("R2 linkResetN high", int'(linkResetN), 1);
  endtask

  task automatic stopLink();
    regWrite(1'b0, 8'h00);
    @(negedge clk);
    chk("R3 entry latency", cyc - lastWrCyc, 0);
    chk("R3 linkResetN low", int'(linkResetN), 0);
    chk("R3 ctrl readback", int'(regRdData[0]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk("R1 linkResetN", int'(linkResetN), 0);
    chk("R1 ctrl", int'(regRdData), 0);
    readStat("R1 status", 0);

    sdIn = 3'b101;
    startLink();
    repeat (WIN + 6) @(posedge clk);
    readStat("R5 lines 0 and 2", 5);
    #1 sdIn = 3'b010;
    repeat (10) @(posedge clk);
    readStat("R6 late line 1 ignored", 5);

    stopLink();
    repeat (30) @(posedge clk);
    readStat("R8 kept across link reset", 5);

    regWrite(1'b1, 8'h01);
    readStat("R7 clear bit 0", 4);
    regWrite(1'b1, 8'h00);
    readStat("R7 zero write no effect", 4);

    startLink();
    regWrite(1'b1, 8'h02);
    readStat("R9 set wins over clear", 6);
    repeat (WIN + 6) @(posedge clk);
    regWrite(1'b1, 8'h02);
    readStat("R7 clear bit 1", 4);

    stopLink();
    regWrite(1'b0, 8'h01);
    repeat (3) @(posedge clk);
    regWrite(1'b0, 8'h00);
    repeat (N + 10) @(posedge clk);
    @(negedge clk);
    chk("R4 aborted start linkResetN", int'(linkResetN), 0);
    chk("R4 aborted start readback", int'(regRdData[0]), 0);

    regWrite(1'b1, 8'h07);
    readStat("R7 clear all", 0);
    sdIn = 3'b111;
    startLink();
    repeat (WIN + 6) @(posedge clk);
    readStat("R5 all lines", 7);
    stopLink();
    regWrite(1'b1, 8'h05);
    readStat("R7 clear bits 0 and 2", 2);
    sdIn = 3'b011;
    startLink();
    repeat (WIN + 6) @(posedge clk);
    readStat("R5 lines 0 and 1", 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule